// File: doc/BRIEF.md
# Two-Leg Halfband Interpolate-by-Two Filter

This block doubles the sample rate of a signed real sample stream with a halfband filter split into two polyphase legs. One leg is a plain delay that carries the original samples (the center tap, scaled to unity). The other leg is a symmetric FIR built from the odd-offset taps. It produces the new samples that fall halfway between the originals. For each input sample the block emits one pair: the filter-leg sample first, then the delay-leg sample.

A static mode pin picks the output arrangement. In merged mode the clock runs at the output rate. The legs advance on every second edge, the phase of those edges is set by a one-cycle sync strobe, and the pairs are interleaved onto one port that carries a new sample every clock. In split mode each edge captures an input, the two legs drive separate ports at the input rate, and a downstream device does the interleaving, taking the filter port first. The mode may only change while reset is held.

Top module: `hbi2_interp`

## Requirements
- R1: With `int_mode`=1, once the first pair reaches the output, `mix_vld` stays high on every following cycle. `mix_out` alternates between filter-leg and delay-leg samples. With `int_mode`=0, `mix_vld` stays low and `mix_out` stays 0.
- R2: With `int_mode`=1, input capture and leg advance happen only on every second rising edge, so `up_out` and `lo_out` change only on edges of the capture parity.
- R3: With `int_mode`=1, no sample is captured after reset until `sync` has been seen high on a rising edge. The first capture is the edge right after that one, and captures repeat every second edge from then on.
- R4: With `int_mode`=0, `din` is captured on every rising edge and `sync` has no effect. `leg_vld` stays high once the first result arrives.
- R5: For captured samples x[0], x[1], … (x of a negative index is 0) and NUNIQ unique coefficients, pair k holds f[k] and d[k] = x[k-NUNIQ+1]. f[k] always comes before d[k]: on `mix_out`, f[k] sits on the cycle before d[k]. In split mode, f[k] goes to `lo_out` and d[k] to `up_out` on the same edge.
- R6: f[k] = floor((Σ_i COEF[i]·(x[k-i] + x[k-2·NUNIQ+1+i]) + 2^(FRAC-1)) / 2^FRAC), computed with no internal overflow and then reduced to its low 16 bits. COEF[0] pairs the newest and oldest taps.
- R7: In split mode, `lo_out` shows f[k] 4 clocks after the edge that captures x[k]. `up_out` shows x[j] 3+NUNIQ clocks after the edge that captures x[j] (7 with the defaults).
- R8: In merged mode, `mix_out` shows f[k] 7 clocks after the edge that captures x[k]. It shows x[j] 6+2·NUNIQ clocks after the edge that captures x[j] (14 with the defaults).
- R9: While `rst_n` is low, all output data ports are 0 and both valid flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; output rate in merged mode, input rate in split mode |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_mode | input | 1 | 1 = merge legs on chip, 0 = separate leg ports; static outside reset |
| sync | input | 1 | Sets the capture phase in merged mode |
| din | input | DW | Signed input sample |
| mix_out | output | DW | Interleaved output stream (merged mode) |
| mix_vld | output | 1 | `mix_out` carries a new sample this cycle |
| up_out | output | DW | Delay-leg output |
| lo_out | output | DW | Filter-leg output |
| leg_vld | output | 1 | Leg ports carry valid results |

## Verification
A wrong capture phase, or a lost sync, shows up on the first pair after the strobe. The interleaved stream would then carry duplicated or skipped originals, or the leg ports would change on the wrong edge parity, within about 14 clocks. A wrong tap, pre-add pairing or coefficient index corrupts f[k] as soon as an impulse reaches that tap, which is at most 2·NUNIQ input samples after it enters. The impulse runs in both modes pin down each leg's latency to the exact clock. Swapped leg order in the merge would be caught on the very first valid output word.

// File: rtl/hbi2_pkg.sv
`timescale 1ns/1ps
package hbi2_pkg;
   typedef enum logic {
      MUX_EXTERNAL = 1'b0,
      MUX_INTERNAL = 1'b1
   } mux_mode_e;

   // register stages between the tap line and the leg result registers
   localparam int LEG_STAGES = 3;
endpackage

// File: rtl/hbi2_phase.sv
`timescale 1ns/1ps
module hbi2_phase (
   input  logic clk,
   input  logic rst_n,
   input  logic int_mode,
   input  logic sync,
   output logic cap,
   output logic capq
);
   logic armed;
   logic ph;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         ph    <= 1'b0;
         capq  <= 1'b0;
      end else begin
         capq <= cap;
         if (sync) begin
            armed <= 1'b1;
            ph    <= 1'b1;
         end else begin
            ph <= ~ph;
         end
      end
   end

   assign cap = int_mode ? (armed & ph) : 1'b1;

   // R3: capture happens on the edge right after sync
   p_first_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (int_mode && sync) |=> cap);

   // R2: legs advance on alternate edges only
   p_half_rate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (int_mode && cap && !sync) |=> !cap);
endmodule

// File: rtl/hbi2_legs.sv
`timescale 1ns/1ps
module hbi2_legs
   import hbi2_pkg::*;
#(
   parameter int DW    = 16,
   parameter int CW    = 16,
   parameter int NUNIQ = 4,
   parameter int FRAC  = 14,
   parameter logic signed [CW-1:0] COEF [NUNIQ] = '{-16'sd290, 16'sd718, -16'sd2104, 16'sd9868}
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 adv,
   input  logic signed [DW-1:0] din,
   output logic signed [DW-1:0] f_out,
   output logic signed [DW-1:0] d_out,
   output logic                 vld_out
);
   localparam int NT = 2 * NUNIQ;
   localparam int PW = DW + 1;
   localparam int MW = PW + CW;
   localparam int AW = MW + $clog2(NUNIQ) + 1;
   localparam logic signed [AW-1:0] HALF = AW'(1) <<< (FRAC - 1);

   if (NUNIQ < 1) begin : g_bad_taps
      $error("NUNIQ must be at least 1");
   end
   if (FRAC < 1 || FRAC >= AW) begin : g_bad_frac
      $error("FRAC out of range");
   end
   if (DW < 2 || CW < 2) begin : g_bad_width
      $error("DW and CW must be at least 2");
   end

   logic signed [DW-1:0] tap   [NT];
   logic signed [MW-1:0] prod_w[NUNIQ];
   logic signed [DW-1:0] dpipe [LEG_STAGES];
   logic [LEG_STAGES:0]  vpipe;
   logic signed [AW-1:0] acc;
   logic signed [DW-1:0] f_r;

   // sample history, newest at index 0
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NT; i++) tap[i] <= '0;
      end else if (adv) begin
         tap[0] <= din;
         for (int i = 1; i < NT; i++) tap[i] <= tap[i-1];
      end
   end

   // one pre-add and multiply lane per unique coefficient
   for (genvar g = 0; g < NUNIQ; g++) begin : g_mac
      logic signed [PW-1:0] pre_q;
      logic signed [MW-1:0] prod_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pre_q  <= '0;
            prod_q <= '0;
         end else if (adv) begin
            pre_q  <= PW'(tap[g]) + PW'(tap[NT-1-g]);
            prod_q <= MW'(pre_q) * MW'(COEF[g]);
         end
      end
      assign prod_w[g] = prod_q;
   end

   always_comb begin
      acc = HALF;
      for (int i = 0; i < NUNIQ; i++) acc = acc + AW'(prod_w[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f_r   <= '0;
         vpipe <= '0;
         for (int i = 0; i < LEG_STAGES; i++) dpipe[i] <= '0;
      end else if (adv) begin
         f_r      <= DW'(acc >>> FRAC);
         vpipe    <= {vpipe[LEG_STAGES-1:0], 1'b1};
         dpipe[0] <= tap[NUNIQ-1];
         for (int i = 1; i < LEG_STAGES; i++) dpipe[i] <= dpipe[i-1];
      end
   end

   assign f_out   = f_r;
   assign d_out   = dpipe[LEG_STAGES-1];
   assign vld_out = vpipe[LEG_STAGES];
endmodule

// File: rtl/hbi2_merge.sv
`timescale 1ns/1ps
module hbi2_merge #(
   parameter int DW = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 int_mode,
   input  logic                 cap,
   input  logic                 capq,
   input  logic signed [DW-1:0] f_in,
   input  logic signed [DW-1:0] d_in,
   input  logic                 vin,
   output logic signed [DW-1:0] up_out,
   output logic signed [DW-1:0] lo_out,
   output logic                 leg_vld,
   output logic signed [DW-1:0] mix_out,
   output logic                 mix_vld
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up_out  <= '0;
         lo_out  <= '0;
         leg_vld <= 1'b0;
      end else if (cap) begin
         up_out  <= d_in;
         lo_out  <= f_in;
         leg_vld <= vin;
      end
   end

   // edge after a leg step carries the filter sample, the step edge the delay sample
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mix_out <= '0;
         mix_vld <= 1'b0;
      end else if (int_mode && vin) begin
         mix_out <= capq ? f_in : d_in;
         mix_vld <= 1'b1;
      end else begin
         mix_vld <= 1'b0;
      end
   end

   // R1: merged stream is continuous once started
   p_mix_steady_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (int_mode && mix_vld) |=> mix_vld);

   // R4: split-mode leg ports stay valid
   p_ext_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!int_mode && leg_vld) |=> leg_vld);

   // R5: the delay sample follows on the step edge, matching the upper leg port
   p_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (int_mode && cap && vin) |=> (mix_out == up_out));
endmodule

// File: rtl/hbi2_interp.sv
`timescale 1ns/1ps
module hbi2_interp
   import hbi2_pkg::*;
#(
   parameter int DW    = 16,
   parameter int CW    = 16,
   parameter int NUNIQ = 4,
   parameter int FRAC  = 14,
   parameter logic signed [CW-1:0] COEF [NUNIQ] = '{-16'sd290, 16'sd718, -16'sd2104, 16'sd9868}
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 int_mode,
   input  logic                 sync,
   input  logic signed [DW-1:0] din,
   output logic signed [DW-1:0] mix_out,
   output logic                 mix_vld,
   output logic signed [DW-1:0] up_out,
   output logic signed [DW-1:0] lo_out,
   output logic                 leg_vld
);
   mux_mode_e            mode;
   logic                 merged;
   logic                 cap;
   logic                 capq;
   logic signed [DW-1:0] f_leg;
   logic signed [DW-1:0] d_leg;
   logic                 v_leg;

   assign mode   = mux_mode_e'(int_mode);
   assign merged = (mode == MUX_INTERNAL);

   hbi2_phase i_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .int_mode (merged),
      .sync     (sync),
      .cap      (cap),
      .capq     (capq)
   );

   hbi2_legs #(
      .DW    (DW),
      .CW    (CW),
      .NUNIQ (NUNIQ),
      .FRAC  (FRAC),
      .COEF  (COEF)
   ) i_legs (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (cap),
      .din     (din),
      .f_out   (f_leg),
      .d_out   (d_leg),
      .vld_out (v_leg)
   );

   hbi2_merge #(
      .DW (DW)
   ) i_merge (
      .clk      (clk),
      .rst_n    (rst_n),
      .int_mode (merged),
      .cap      (cap),
      .capq     (capq),
      .f_in     (f_leg),
      .d_in     (d_leg),
      .vin      (v_leg),
      .up_out   (up_out),
      .lo_out   (lo_out),
      .leg_vld  (leg_vld),
      .mix_out  (mix_out),
      .mix_vld  (mix_vld)
   );
endmodule

// File: tb/test_hbi2_interp.sv
`timescale 1ns/1ps
module test_hbi2_interp;
   localparam int NU   = 4;
   localparam int FRAC = 14;
   localparam logic signed [15:0] CF [NU] = '{-16'sd290, 16'sd718, -16'sd2104, 16'sd9868};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic int_mode = 1'b0;
   logic sync = 1'b0;
   logic signed [15:0] din = '0;
   logic signed [15:0] mix_out, up_out, lo_out;
   logic mix_vld, leg_vld;

   hbi2_interp #(.DW(16), .CW(16), .NUNIQ(NU), .FRAC(FRAC), .COEF(CF)) i_hbi2_interp (
      .clk(clk), .rst_n(rst_n), .int_mode(int_mode), .sync(sync), .din(din),
      .mix_out(mix_out), .mix_vld(mix_vld), .up_out(up_out), .lo_out(lo_out),
      .leg_vld(leg_vld)
   );

   always #2 clk = ~clk;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   int t0 = -1;
   int first_lo, first_up, first_mixf, first_mixd;
   bit mon_on = 1'b0;
   logic signed [15:0] prev_up = '0;
   int hist[$];
   logic signed [15:0] q_mix[$], q_up[$], q_lo[$];

   always @(posedge clk) cyc++;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   function automatic int xat(input int j);
      return (j < 0) ? 0 : hist[j];
   endfunction

   function automatic logic signed [15:0] fexp(input int k);
      longint acc = 0;
      for (int i = 0; i < NU; i++)
         acc += longint'(CF[i]) * longint'(xat(k - i) + xat(k - 2*NU + 1 + i));
      acc += longint'(1) <<< (FRAC - 1);
      acc = acc >>> FRAC;
      return acc[15:0];
   endfunction

   task automatic push_sample(input int v);
      int k;
      logic signed [15:0] f, d;
      hist.push_back(v);
      k = hist.size() - 1;
      f = fexp(k);
      d = 16'(xat(k - NU + 1));
      if (t0 < 0) t0 = cyc + 1;
      if (int_mode) begin
         q_mix.push_back(f);
         q_mix.push_back(d);
      end else begin
         q_lo.push_back(f);
         q_up.push_back(d);
      end
   endtask

   // split mode: one capture per edge, sync toggled freely (R4)
   task automatic feed_ext(input int v);
      din  = 16'(v);
      sync = 1'($urandom_range(0, 1));
      push_sample(v);
      @(negedge clk);
   endtask

   task automatic feed_int(input int v);
      din = 16'(v);
      push_sample(v);
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic start_int();
      sync = 1'b1;
      @(negedge clk);
      sync = 1'b0;
   endtask

   task automatic do_reset(input bit mode);
      @(negedge clk);
      mon_on   = 1'b0;
      rst_n    = 1'b0;
      int_mode = mode;
      din      = '0;
      sync     = 1'b0;
      hist.delete(); q_mix.delete(); q_up.delete(); q_lo.delete();
      t0 = -1; first_lo = -1; first_up = -1; first_mixf = -1; first_mixd = -1;
      prev_up = '0;
      repeat (3) @(negedge clk);
      check(mix_out == 0 && up_out == 0 && lo_out == 0, "R9 data reset", int'(mix_out | up_out | lo_out), 0);
      check(!mix_vld && !leg_vld, "R9 valid reset", int'({mix_vld, leg_vld}), 0);
      rst_n  = 1'b1;
      mon_on = 1'b1;
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (mon_on && rst_n) begin
         if (!int_mode) begin
            check(!mix_vld && mix_out == 0, "R1 merged port idle in split mode", int'(mix_vld), 0);
            if (first_lo < 0 && lo_out != 0) first_lo = cyc;
            if (first_up < 0 && up_out == 16'sd1000) first_up = cyc;
            if (leg_vld) begin
               if (q_lo.size() == 0) check(1'b0, "R5 split queue empty", 0, 1);
               else begin
                  logic signed [15:0] ef, ed;
                  ef = q_lo.pop_front();
                  ed = q_up.pop_front();
                  check(lo_out == ef, "R6 R5 lo_out filter sample", int'(lo_out), int'(ef));
                  check(up_out == ed, "R5 up_out delay sample", int'(up_out), int'(ed));
               end
            end
         end else begin
            if (first_mixf < 0 && mix_vld && mix_out != 0) first_mixf = cyc;
            if (first_mixd < 0 && mix_vld && mix_out == 16'sd1000) first_mixd = cyc;
            if (mix_vld) begin
               if (q_mix.size() == 0) check(1'b0, "R1 merged queue empty", 0, 1);
               else begin
                  logic signed [15:0] em;
                  em = q_mix.pop_front();
                  check(mix_out == em, "R1 R5 R6 mix_out", int'(mix_out), int'(em));
               end
            end
            if (up_out != prev_up) begin
               check(t0 >= 0 && ((cyc - t0) % 2) == 0, "R2 leg port change parity", cyc - t0, 0);
               prev_up = up_out;
            end
         end
      end
   end

   task automatic finish_up();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(200000 * 4);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_up();
   end

   initial begin
      // split mode: impulse, random data, drain
      do_reset(1'b0);
      feed_ext(1000);
      for (int i = 0; i < 20; i++) feed_ext(0);
      for (int i = 0; i < 60; i++) feed_ext(int'($urandom_range(0, 65535)) - 32768);
      for (int i = 0; i < 10; i++) feed_ext(0);
      check(first_lo - t0 == 4, "R7 filter leg latency split", first_lo - t0, 4);
      check(first_up - t0 == 3 + NU, "R7 delay leg latency split", first_up - t0, 3 + NU);

      // merged mode: nothing captured before sync
      do_reset(1'b1);
      din = 16'sd12345;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (i % 5 == 4)
            check(!mix_vld && !leg_vld, "R3 no capture before sync", int'({mix_vld, leg_vld}), 0);
      end
      din = '0;
      start_int();
      feed_int(1000);
      for (int i = 0; i < 20; i++) feed_int(0);
      for (int i = 0; i < 60; i++) feed_int(int'($urandom_range(0, 65535)) - 32768);
      for (int i = 0; i < 12; i++) feed_int(0);
      check(first_mixf - t0 == 7, "R8 R3 filter sample latency merged", first_mixf - t0, 7);
      check(first_mixd - t0 == 6 + 2*NU, "R8 delay sample latency merged", first_mixd - t0, 6 + 2*NU);

      // full-scale patterns in both modes
      do_reset(1'b0);
      for (int i = 0; i < 30; i++) feed_ext(32767);
      for (int i = 0; i < 30; i++) feed_ext((i % 2) ? 32767 : -32768);
      for (int i = 0; i < 30; i++) feed_ext((i % 3 == 0) ? -32768 : 32767);
      for (int i = 0; i < 10; i++) feed_ext(0);

      do_reset(1'b1);
      start_int();
      for (int i = 0; i < 30; i++) feed_int(-32768);
      for (int i = 0; i < 30; i++) feed_int((i % 2) ? 32767 : -32768);
      for (int i = 0; i < 30; i++) feed_int((i % 3 == 0) ? 32767 : -32768);
      for (int i = 0; i < 12; i++) feed_int(0);

      mon_on = 1'b0;
      finish_up();
   end
endmodule